// File: doc/BRIEF.md
# Latency-Hiding Warp Issue Scheduler

This block sits between a shared instruction front end and a fixed-latency execution pipeline. Each resident warp offers its next decoded instruction: a valid flag, a destination register and two source registers. A per-warp scoreboard keeps one busy bit for each register. An instruction whose sources or destination are still being produced is held back. In that slot the scheduler grants a different ready warp, so a long pipeline stays busy when enough warps are resident.

One instruction leaves per clock on a registered issue strobe, which carries the warp number and the destination register. The execution pipeline is modelled as a tag shift line of `LATENCY` stages. When a tag reaches the end of the line, the block raises a writeback notification and releases the matching busy bit. The upstream front end must present a warp's next instruction in the cycle in which that warp appears on the issue strobe.

Top module: `warp_issue_sched`

## Requirements
- R1: At most one instruction issues per clock. The strobe `issue_vld` is high in the cycle after the edge that took the instruction, and `issue_warp` and `issue_dst` are the warp number and destination register that were presented before that edge.
- R2: An instruction is held while its warp has a busy bit set for its first source, its second source or its destination. A dependent instruction issues exactly `LATENCY` cycles after the strobe of the instruction that produces its register. The default `LATENCY` is 22, and the parameter accepts any value from 2 to 64.
- R3: When one warp is held by a busy register, another warp with a ready instruction takes the slot in the same cycle. The issue stream has no gap as long as such a warp exists.
- R4: Grants rotate round-robin, starting at the warp after the last one issued. After reset the first grant goes to warp 0.
- R5: The warp shown on the strobe is not eligible in the following slot. A lone warp with independent instructions therefore issues every second cycle.
- R6: When no warp has a ready instruction, `issue_vld` stays low.
- R7: `wb_vld` pulses `LATENCY-1` cycles after the issue strobe and carries the same warp and destination. The busy bit is released in that cycle, so a waiting instruction may be selected then.
- R8: If the release of a register and a new claim of the same register by the same warp fall on the same edge, the claim wins and the register stays busy.
- R9: With 8 warps and a depth of 22, where each instruction depends on the one three places earlier in its warp, the block issues one instruction every cycle.
- R10: Reset drives `issue_vld` and `wb_vld` low, clears every busy bit and empties the pipeline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| w_vld | input | NUM_WARPS | Per-warp next-instruction valid |
| w_dst | input | NUM_WARPS*RW | Per-warp destination register |
| w_srca | input | NUM_WARPS*RW | Per-warp first source register |
| w_srcb | input | NUM_WARPS*RW | Per-warp second source register |
| issue_vld | output | 1 | Issue strobe |
| issue_warp | output | WW | Warp issued |
| issue_dst | output | RW | Destination of the issued instruction |
| wb_vld | output | 1 | Writeback completion pulse |
| wb_warp | output | WW | Warp whose result completes |
| wb_dst | output | RW | Register released |

## Verification
Two events can land on the same clock edge: a register is released at the end of the pipeline, and the same warp issues a new instruction that writes that register again. The bench sets this up with a chain in which the second instruction both reads and rewrites the first one's destination. That makes it issue exactly on the release edge. A third instruction reads the register, and the bench checks that it waits a full `LATENCY` after the second, not after the first.

// File: rtl/wsched_pkg.sv
package wsched_pkg;
  localparam int DEF_WARPS   = 8;
  localparam int DEF_REGS    = 8;
  localparam int DEF_LATENCY = 22;
endpackage

// File: rtl/wsched_scoreboard.sv
module wsched_scoreboard #(
  parameter int NW = 8,
  parameter int NR = 8,
  parameter int WW = 3,
  parameter int RW = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_en,
  input  logic [WW-1:0]     set_warp,
  input  logic [RW-1:0]     set_reg,
  input  logic              clr_en,
  input  logic [WW-1:0]     clr_warp,
  input  logic [RW-1:0]     clr_reg,
  input  logic [NW*RW-1:0]  dst,
  input  logic [NW*RW-1:0]  srca,
  input  logic [NW*RW-1:0]  srcb,
  output logic [NW-1:0]     hazard
);
  logic [NW-1:0][NR-1:0] busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= '0;
    end else begin
      if (clr_en) busy_q[clr_warp][clr_reg] <= 1'b0;
      if (set_en) busy_q[set_warp][set_reg] <= 1'b1;
    end
  end

  for (genvar g = 0; g < NW; g++) begin : g_warp
    logic [NR-1:0] live;
    always_comb begin
      live = busy_q[g];
      if (clr_en && (int'(clr_warp) == g)) live[clr_reg] = 1'b0;
      hazard[g] = live[srca[g*RW +: RW]] | live[srcb[g*RW +: RW]]
                | live[dst[g*RW +: RW]];
    end
  end
endmodule

// File: rtl/wsched_rr_arb.sv
module wsched_rr_arb #(
  parameter int NW = 8,
  parameter int WW = 3
) (
  input  logic [NW-1:0] req,
  input  logic [WW-1:0] last,
  output logic          gnt_vld,
  output logic [WW-1:0] gnt_idx
);
  int k;
  always_comb begin
    gnt_vld = 1'b0;
    gnt_idx = '0;
    k = 0;
    for (int i = 1; i <= NW; i++) begin
      k = (int'(last) + i) % NW;
      if (!gnt_vld && req[k]) begin
        gnt_vld = 1'b1;
        gnt_idx = WW'(k);
      end
    end
  end
endmodule

// File: rtl/wsched_tag_line.sv
module wsched_tag_line #(
  parameter int DEPTH = 22,
  parameter int TW    = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_vld,
  input  logic [TW-1:0] in_tag,
  output logic          out_vld,
  output logic [TW-1:0] out_tag
);
  logic [DEPTH-1:0] vld_q;
  logic [TW-1:0]    tag_q [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) vld_q <= '0;
    else     vld_q <= {vld_q[DEPTH-2:0], in_vld};
  end

  always_ff @(posedge clk) begin
    tag_q[0] <= in_tag;
    for (int i = 1; i < DEPTH; i++) tag_q[i] <= tag_q[i-1];
  end

  assign out_vld = vld_q[DEPTH-1];
  assign out_tag = tag_q[DEPTH-1];
endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched #(
  parameter int NUM_WARPS = wsched_pkg::DEF_WARPS,
  parameter int NUM_REGS  = wsched_pkg::DEF_REGS,
  parameter int LATENCY   = wsched_pkg::DEF_LATENCY,
  localparam int WW = $clog2(NUM_WARPS),
  localparam int RW = $clog2(NUM_REGS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_WARPS-1:0]  w_vld,
  input  logic [NUM_WARPS*RW-1:0] w_dst,
  input  logic [NUM_WARPS*RW-1:0] w_srca,
  input  logic [NUM_WARPS*RW-1:0] w_srcb,
  output logic                  issue_vld,
  output logic [WW-1:0]         issue_warp,
  output logic [RW-1:0]         issue_dst,
  output logic                  wb_vld,
  output logic [WW-1:0]         wb_warp,
  output logic [RW-1:0]         wb_dst
);
  localparam int TW = WW + RW;

  logic [NUM_WARPS-1:0] hazard, shown, eligible;
  logic                 gnt_vld;
  logic [WW-1:0]        gnt_idx, last_q;
  logic [RW-1:0]        gnt_dst;
  logic [TW-1:0]        out_tag;

  always_comb begin
    shown = '0;
    if (issue_vld) shown[issue_warp] = 1'b1;
  end

  assign eligible = w_vld & ~hazard & ~shown;
  assign gnt_dst  = w_dst[int'(gnt_idx)*RW +: RW];

  wsched_scoreboard #(.NW(NUM_WARPS), .NR(NUM_REGS), .WW(WW), .RW(RW)) sb_i (
    .clk(clk), .rst(rst),
    .set_en(gnt_vld), .set_warp(gnt_idx), .set_reg(gnt_dst),
    .clr_en(wb_vld), .clr_warp(wb_warp), .clr_reg(wb_dst),
    .dst(w_dst), .srca(w_srca), .srcb(w_srcb), .hazard(hazard)
  );

  wsched_rr_arb #(.NW(NUM_WARPS), .WW(WW)) arb_i (
    .req(eligible), .last(last_q), .gnt_vld(gnt_vld), .gnt_idx(gnt_idx)
  );

  wsched_tag_line #(.DEPTH(LATENCY), .TW(TW)) line_i (
    .clk(clk), .rst(rst),
    .in_vld(gnt_vld), .in_tag({gnt_idx, gnt_dst}),
    .out_vld(wb_vld), .out_tag(out_tag)
  );

  assign wb_warp = out_tag[TW-1:RW];
  assign wb_dst  = out_tag[RW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      issue_vld  <= 1'b0;
      issue_warp <= '0;
      issue_dst  <= '0;
      last_q     <= WW'(NUM_WARPS - 1);
    end else begin
      issue_vld <= gnt_vld;
      if (gnt_vld) begin
        issue_warp <= gnt_idx;
        issue_dst  <= gnt_dst;
        last_q     <= gnt_idx;
      end
    end
  end
endmodule

// File: rtl/warp_issue_sched_chk.sv
module warp_issue_sched_chk #(
  parameter int W  = 8,
  parameter int WW = 3,
  parameter int RW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic [W-1:0]  w_vld,
  input logic [W*RW-1:0] w_dst,
  input logic          issue_vld,
  input logic [WW-1:0] issue_warp,
  input logic [RW-1:0] issue_dst,
  input logic          wb_vld
);
  logic [W-1:0]    prev_vld;
  logic [W*RW-1:0] prev_dst;
  always_ff @(posedge clk) begin
    prev_vld <= w_vld;
    prev_dst <= w_dst;
  end

  // R1
  issue_matches_offer_chk: assert property (@(posedge clk) disable iff (rst)
    issue_vld |-> (prev_vld[issue_warp] && issue_dst == prev_dst[int'(issue_warp)*RW +: RW]));

  // R6
  idle_bubble_chk: assert property (@(posedge clk) disable iff (rst)
    !(|prev_vld) |-> !issue_vld);

  // R5
  no_repeat_warp_chk: assert property (@(posedge clk) disable iff (rst)
    (issue_vld && $past(issue_vld)) |-> (issue_warp != $past(issue_warp)));

  // R10
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!issue_vld && !wb_vld));
endmodule

bind warp_issue_sched warp_issue_sched_chk #(.W(NUM_WARPS), .WW(WW), .RW(RW)) chk_i (
  .clk(clk), .rst(rst), .w_vld(w_vld), .w_dst(w_dst),
  .issue_vld(issue_vld), .issue_warp(issue_warp), .issue_dst(issue_dst),
  .wb_vld(wb_vld)
);

// File: tb/warp_issue_sched_tb_top.sv
`timescale 1ns/1ps
module warp_issue_sched_tb_top;
  localparam int NW = 8;
  localparam int RW = 3;
  localparam int WW = 3;
  localparam int LAT = 22;
  localparam int MAXI = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NW-1:0]    w_vld = '0;
  logic [NW*RW-1:0] w_dst = '0, w_srca = '0, w_srcb = '0;
  logic issue_vld, wb_vld;
  logic [WW-1:0] issue_warp, wb_warp;
  logic [RW-1:0] issue_dst, wb_dst;

  always #5 clk = ~clk;

  warp_issue_sched #(.NUM_WARPS(NW), .NUM_REGS(8), .LATENCY(LAT)) dut_i (
    .clk(clk), .rst(rst), .w_vld(w_vld), .w_dst(w_dst), .w_srca(w_srca),
    .w_srcb(w_srcb), .issue_vld(issue_vld), .issue_warp(issue_warp),
    .issue_dst(issue_dst), .wb_vld(wb_vld), .wb_warp(wb_warp), .wb_dst(wb_dst)
  );

  int total = 0, bad = 0;
  int p_dst [NW][MAXI];
  int p_sa  [NW][MAXI];
  int p_sb  [NW][MAXI];
  int n_ins [NW];
  int ptr   [NW];
  int iss   [NW][MAXI];
  int wb_cyc[NW];
  int wb_d  [NW];
  int cyc, n_iss, wb_cnt;

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_prog();
    for (int w = 0; w < NW; w++) begin
      n_ins[w] = 0; ptr[w] = 0; wb_cyc[w] = -1; wb_d[w] = -1;
      for (int k = 0; k < MAXI; k++) begin
        p_dst[w][k] = 0; p_sa[w][k] = 0; p_sb[w][k] = 0; iss[w][k] = -1;
      end
    end
    cyc = 0; n_iss = 0; wb_cnt = 0;
  endtask

  task automatic add(int w, int d, int a, int b);
    p_dst[w][n_ins[w]] = d; p_sa[w][n_ins[w]] = a; p_sb[w][n_ins[w]] = b;
    n_ins[w]++;
  endtask

  task automatic present();
    w_vld = '0;
    for (int w = 0; w < NW; w++) begin
      if (ptr[w] < n_ins[w]) begin
        w_vld[w] = 1'b1;
        w_dst[w*RW +: RW]  = RW'(p_dst[w][ptr[w]]);
        w_srca[w*RW +: RW] = RW'(p_sa[w][ptr[w]]);
        w_srcb[w*RW +: RW] = RW'(p_sb[w][ptr[w]]);
      end
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; w_vld = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    clear_prog();
  endtask

  task automatic run(int ncyc);
    present();
    for (int c = 0; c < ncyc; c++) begin
      @(negedge clk);
      cyc++;
      if (issue_vld) begin
        int w;
        w = int'(issue_warp);
        n_iss++;
        if (ptr[w] < n_ins[w]) begin
          iss[w][ptr[w]] = cyc;
          chk(int'(issue_dst) == p_dst[w][ptr[w]], "R1 issue_dst", int'(issue_dst), p_dst[w][ptr[w]]);
          ptr[w]++;
        end else chk(1'b0, "R1 unexpected issue", w, -1);
      end
      if (wb_vld) begin
        wb_cnt++;
        if (wb_cyc[wb_warp] < 0) begin
          wb_cyc[wb_warp] = cyc; wb_d[wb_warp] = int'(wb_dst);
        end
      end
      present();
    end
  endtask

  task automatic t_reset();
    do_reset();
    chk(issue_vld == 1'b0, "R10 issue_vld after reset", int'(issue_vld), 0);
    chk(wb_vld == 1'b0, "R10 wb_vld after reset", int'(wb_vld), 0);
    add(1, 4, 0, 0);
    run(3);
    do_reset();
    add(1, 5, 4, 4);
    run(3);
    chk(iss[1][0] == 1, "R10 busy bit cleared by reset", iss[1][0], 1);
  endtask

  task automatic t_bubble();
    do_reset();
    run(6);
    chk(n_iss == 0, "R6 no issue without offers", n_iss, 0);
  endtask

  task automatic t_dep();
    do_reset();
    add(2, 5, 0, 0);
    add(2, 6, 5, 5);
    run(LAT + 30);
    chk(iss[2][1] - iss[2][0] == LAT, "R2 dependent spacing", iss[2][1] - iss[2][0], LAT);
    chk(wb_cyc[2] == iss[2][0] + LAT - 1, "R7 writeback timing", wb_cyc[2], iss[2][0] + LAT - 1);
    chk(wb_d[2] == 5, "R7 writeback register", wb_d[2], 5);
    chk(n_iss == 2, "R6 bubbles while waiting", n_iss, 2);
  endtask

  task automatic t_switch();
    int mx;
    do_reset();
    add(0, 1, 0, 0);
    add(0, 2, 1, 1);
    for (int k = 0; k < 4; k++) begin
      add(3, 3 + k, 0, 0);
      add(5, 3 + k, 0, 0);
    end
    run(LAT + 10);
    mx = 0;
    for (int k = 0; k < 4; k++) begin
      if (iss[3][k] > mx) mx = iss[3][k];
      if (iss[5][k] > mx) mx = iss[5][k];
    end
    chk(iss[0][0] == 1, "R4 first grant warp 0", iss[0][0], 1);
    chk(mx == iss[0][0] + 8, "R3 no gap while warp 0 held", mx, iss[0][0] + 8);
    chk(iss[0][1] - iss[0][0] == LAT, "R2 held warp waits", iss[0][1] - iss[0][0], LAT);
  endtask

  task automatic t_rr();
    do_reset();
    for (int w = 0; w < NW; w++)
      for (int k = 0; k < 3; k++) add(w, k + 1, 0, 0);
    run(40);
    for (int w = 0; w < NW; w++)
      for (int k = 0; k < 3; k++)
        chk(iss[w][k] == iss[0][0] + 8*k + w, "R4 rotation order", iss[w][k], iss[0][0] + 8*k + w);
  endtask

  task automatic t_single();
    do_reset();
    for (int k = 0; k < 3; k++) add(4, k + 1, 0, 0);
    run(12);
    chk(iss[4][1] - iss[4][0] == 2, "R5 lone warp spacing", iss[4][1] - iss[4][0], 2);
    chk(iss[4][2] - iss[4][1] == 2, "R5 lone warp spacing", iss[4][2] - iss[4][1], 2);
  endtask

  task automatic t_waw();
    do_reset();
    add(1, 4, 0, 0);
    add(1, 4, 4, 4);
    add(1, 5, 4, 0);
    run(3*LAT + 10);
    chk(iss[1][1] - iss[1][0] == LAT, "R8 rewrite on release edge", iss[1][1] - iss[1][0], LAT);
    chk(iss[1][2] - iss[1][1] == LAT, "R8 claim wins over release", iss[1][2] - iss[1][1], LAT);
  endtask

  task automatic t_thru();
    int nbad;
    do_reset();
    for (int w = 0; w < NW; w++)
      for (int k = 0; k < 12; k++) add(w, (k % 3) + 1, (k % 3) + 1, (k % 3) + 1);
    run(96 + LAT + 20);
    nbad = 0;
    for (int w = 0; w < NW; w++)
      for (int k = 0; k < 12; k++)
        if (iss[w][k] != iss[0][0] + 8*k + w) nbad++;
    chk(nbad == 0, "R9 one issue per cycle", nbad, 0);
    chk(n_iss == 96, "R9 all issued", n_iss, 96);
    chk(wb_cnt == 96, "R7 all written back", wb_cnt, 96);
  endtask

  initial begin
    #1000000;
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_bubble();
    t_dep();
    t_switch();
    t_rr();
    t_single();
    t_waw();
    t_thru();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule